// File: doc/BRIEF.md
# Four-Lookup-Table Distributed RAM Slice

The block models a logic slice whose four 64-bit lookup tables can each serve as a small RAM. Writes are synchronous. Reads are asynchronous. The tables are numbered 0 to 3 and are called A, B, C and D, with D as the master table. A mode input for each table picks one of the following shapes:

- one bit wide and 64 deep;
- two bits wide and 32 deep;
- either of the two shapes in single-port form, where the table writes and reads at its own address pins;
- either of the two shapes in dual-port form, where the table reads at its own pins but writes at the master's address pins.

All tables share a single clock and a single write enable. Each table drives two outputs, a primary output and a secondary output.

The master table always acts as the write-and-read port, so it must run in a single-port RAM mode whenever any table of the slice is used as memory. When dual-port tables are used, their low data bit comes from the master's data input. Table A takes its low data bit from whatever source feeds table B's low bit. Any illegal mix of modes raises an error output and blocks every write.

Top module: `dram_slice`

## Requirements
- R1: Mode codes are 0 off, 1 single-port 32x2, 2 dual-port 32x2, 3 single-port 64x1 and 4 dual-port 64x1. Codes 5 to 7 are invalid. Each table holds 64 bits. A write takes effect at the rising clock edge when `we_i` is high and `cfg_err_o` is low. Reads are combinational, so before that edge the old data shows at the write address.
- R2: In single-port 64x1 mode, a table writes and reads the bit at its own 6-bit address using its own `lut_din_i` bit. `o6_o` returns that bit and `o5_o` is 0.
- R3: In both 32x2 modes, only address bits 4..0 count and bit 5 is ignored. `o6_o` returns the high data bit and `o5_o` the low data bit at that address. In single-port 32x2 mode the high bit written is the table's own `lut_byp_i` bit and the low bit is its own `lut_din_i` bit.
- R4: In both dual-port modes, a table writes at the address on the master table's (index 3) pins and reads at its own pins.
- R5: In a dual-port mode, tables B (1) and C (2) write the master's `lut_din_i` bit as their low data bit. Table A (0) writes B's low data source instead: the master's bit when B is dual-port, and B's own `lut_din_i` bit otherwise.
- R6: In dual-port 32x2 mode, the high data bit written is the table's own `lut_byp_i` bit.
- R7: `cfg_err_o` is high when any table holds an invalid code. It is also high when any table is not off and the master is not in mode 1 or 3. Otherwise it is low.
- R8: While `cfg_err_o` is high, no table is written.
- R9: A table in mode 0 drives both outputs low and is never written.
- R10: Reset clears every stored bit to zero.
- R11: While `we_i` is low, stored data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes on its rising edge |
| rst_ni | input | 1 | Active-low reset, clears storage |
| we_i | input | 1 | Write enable shared by all tables |
| lut_mode_i | input | 4x3 | Mode code per table (index 3 = master) |
| lut_addr_i | input | 4x6 | Address pins per table |
| lut_byp_i | input | 4 | Bypass input per table (high data bit) |
| lut_din_i | input | 4 | Data input per table (low data bit) |
| o6_o | output | 4 | Primary read output per table |
| o5_o | output | 4 | Secondary read output per table |
| cfg_err_o | output | 1 | Illegal mode combination flag |

## Verification
Read outputs and the error flag are combinational, so they are due in the same cycle their inputs change. The bench samples them 1 ns after driving, before the next rising edge, which also confirms that each table still shows its old data. A write becomes visible only after the following rising edge, so the bench samples the outputs again 2 ns after that edge, with the same inputs held, and compares them against its own model, updated at that edge. The reset checks release reset on a falling edge and read several addresses in the same cycle.

// File: rtl/dram_slice_pkg.sv
package dram_slice_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF = 3'd0,
        MODE_S32 = 3'd1,
        MODE_D32 = 3'd2,
        MODE_S64 = 3'd3,
        MODE_D64 = 3'd4
    } lut_mode_e;

    function automatic logic mode_is_dual(input logic [MODE_W-1:0] m);
        return (m == MODE_D32) || (m == MODE_D64);
    endfunction

    function automatic logic mode_is_single(input logic [MODE_W-1:0] m);
        return (m == MODE_S32) || (m == MODE_S64);
    endfunction

    function automatic logic mode_is_pair(input logic [MODE_W-1:0] m);
        return (m == MODE_S32) || (m == MODE_D32);
    endfunction

    function automatic logic mode_is_bit(input logic [MODE_W-1:0] m);
        return (m == MODE_S64) || (m == MODE_D64);
    endfunction

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return m <= MODE_D64;
    endfunction

endpackage

// File: rtl/dram_mode_check.sv
module dram_mode_check
    import dram_slice_pkg::*;
#(
    parameter int NUM_LUT = 4
) (
    input  logic [NUM_LUT-1:0][MODE_W-1:0] lut_mode_i,
    output logic                           cfg_err_o
);
    localparam int MASTER = NUM_LUT - 1;

    logic bad_code;
    logic any_ram;

    always_comb begin
        bad_code = 1'b0;
        any_ram  = 1'b0;
        for (int k = 0; k < NUM_LUT; k++) begin
            if (!mode_is_legal(lut_mode_i[k])) bad_code = 1'b1;
            if (lut_mode_i[k] != MODE_OFF)     any_ram  = 1'b1;
        end
        // master must be a single-port RAM as soon as any table stores data
        cfg_err_o = bad_code || (any_ram && !mode_is_single(lut_mode_i[MASTER]));
    end

endmodule

// File: rtl/dram_lut_port.sv
module dram_lut_port
    import dram_slice_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [MODE_W-1:0]        mode_i,
    input  logic [ADDR_W-1:0]        own_addr_i,
    input  logic [ADDR_W-1:0]        master_addr_i,
    input  logic                     hi_bit_i,
    input  logic                     lo_bit_i,
    input  logic [(1<<ADDR_W)-1:0]   row_i,
    output logic [(1<<ADDR_W)-1:0]   wmask_o,
    output logic [(1<<ADDR_W)-1:0]   wval_o,
    output logic                     o6_o,
    output logic                     o5_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HALF_W = ADDR_W - 1;

    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] hi_wr_idx, lo_wr_idx, hi_rd_idx, lo_rd_idx;

    always_comb begin
        wr_addr   = mode_is_dual(mode_i) ? master_addr_i : own_addr_i;
        // paired mode: top half of the row holds the high bit, bottom half the low bit
        hi_wr_idx = {1'b1, wr_addr[HALF_W-1:0]};
        lo_wr_idx = {1'b0, wr_addr[HALF_W-1:0]};
        hi_rd_idx = {1'b1, own_addr_i[HALF_W-1:0]};
        lo_rd_idx = {1'b0, own_addr_i[HALF_W-1:0]};
    end

    always_comb begin
        wmask_o = '0;
        wval_o  = '0;
        if (mode_is_pair(mode_i)) begin
            wmask_o[hi_wr_idx] = 1'b1;
            wval_o[hi_wr_idx]  = hi_bit_i;
            wmask_o[lo_wr_idx] = 1'b1;
            wval_o[lo_wr_idx]  = lo_bit_i;
        end else if (mode_is_bit(mode_i)) begin
            wmask_o[wr_addr]   = 1'b1;
            wval_o[wr_addr]    = lo_bit_i;
        end
    end

    always_comb begin
        o6_o = 1'b0;
        o5_o = 1'b0;
        if (mode_is_pair(mode_i)) begin
            o6_o = row_i[hi_rd_idx];
            o5_o = row_i[lo_rd_idx];
        end else if (mode_is_bit(mode_i)) begin
            o6_o = row_i[own_addr_i];
        end
    end

    logic unused_depth;
    assign unused_depth = (DEPTH == 0);

endmodule

// File: rtl/dram_slice.sv
module dram_slice
    import dram_slice_pkg::*;
#(
    parameter int NUM_LUT = 4,
    parameter int ADDR_W  = 6
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [NUM_LUT-1:0][MODE_W-1:0] lut_mode_i,
    input  logic [NUM_LUT-1:0][ADDR_W-1:0] lut_addr_i,
    input  logic [NUM_LUT-1:0]             lut_byp_i,
    input  logic [NUM_LUT-1:0]             lut_din_i,
    output logic [NUM_LUT-1:0]             o6_o,
    output logic [NUM_LUT-1:0]             o5_o,
    output logic                           cfg_err_o
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MASTER = NUM_LUT - 1;

    typedef struct packed {
        logic [NUM_LUT-1:0][DEPTH-1:0] mem;
    } slice_state_t;

    slice_state_t state_d, state_q;

    logic [NUM_LUT-1:0]            lo_src;
    logic [NUM_LUT-1:0][DEPTH-1:0] wmask;
    logic [NUM_LUT-1:0][DEPTH-1:0] wval;

    dram_mode_check #(.NUM_LUT(NUM_LUT)) i_mode_check (
        .lut_mode_i (lut_mode_i),
        .cfg_err_o  (cfg_err_o)
    );

    // low data bit routing: dual-port tables take the master's input,
    // table 0 follows whatever feeds table 1
    for (genvar k = 0; k < NUM_LUT; k++) begin : g_lo
        if (k == 0) begin : g_chain
            assign lo_src[k] = mode_is_dual(lut_mode_i[k]) ? lo_src[1] : lut_din_i[k];
        end else begin : g_direct
            assign lo_src[k] = mode_is_dual(lut_mode_i[k]) ? lut_din_i[MASTER] : lut_din_i[k];
        end
    end

    for (genvar k = 0; k < NUM_LUT; k++) begin : g_lut
        dram_lut_port #(.ADDR_W(ADDR_W)) i_port (
            .mode_i        (lut_mode_i[k]),
            .own_addr_i    (lut_addr_i[k]),
            .master_addr_i (lut_addr_i[MASTER]),
            .hi_bit_i      (lut_byp_i[k]),
            .lo_bit_i      (lo_src[k]),
            .row_i         (state_q.mem[k]),
            .wmask_o       (wmask[k]),
            .wval_o        (wval[k]),
            .o6_o          (o6_o[k]),
            .o5_o          (o5_o[k])
        );
    end

    always_comb begin
        state_d = state_q;
        if (we_i && !cfg_err_o) begin
            for (int k = 0; k < NUM_LUT; k++) begin
                state_d.mem[k] = (state_q.mem[k] & ~wmask[k]) | (wval[k] & wmask[k]);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

endmodule

// File: rtl/dram_slice_chk.sv
module dram_slice_chk
    import dram_slice_pkg::*;
#(
    parameter int NUM_LUT = 4,
    parameter int ADDR_W  = 6
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           we_i,
    input  logic [NUM_LUT-1:0][MODE_W-1:0] lut_mode_i,
    input  logic [NUM_LUT-1:0][ADDR_W-1:0] lut_addr_i,
    input  logic [NUM_LUT-1:0]             lut_byp_i,
    input  logic [NUM_LUT-1:0]             lut_din_i,
    input  logic [NUM_LUT-1:0]             o6_o,
    input  logic [NUM_LUT-1:0]             o5_o,
    input  logic                           cfg_err_o
);
    localparam int MASTER = NUM_LUT - 1;

    for (genvar k = 0; k < NUM_LUT; k++) begin : g_lut_chk
        // R2
        bit_mode_o5_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lut_mode_i[k] == MODE_S64) |-> (o5_o[k] == 1'b0));

        // R9
        off_mode_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (lut_mode_i[k] == MODE_OFF) |-> (o6_o[k] == 1'b0 && o5_o[k] == 1'b0));

        // R2
        bit_write_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (we_i && !cfg_err_o && lut_mode_i[k] == MODE_S64) |=>
            (!$stable(lut_addr_i[k]) || !$stable(lut_mode_i[k]) ||
             o6_o[k] == $past(lut_din_i[k])));
    end

    // R7
    master_needed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lut_mode_i[0] != MODE_OFF && lut_mode_i[MASTER] == MODE_OFF) |-> cfg_err_o);

    // R8 R11
    no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!we_i || cfg_err_o) |=>
        (!$stable(lut_addr_i) || !$stable(lut_mode_i) ||
         ($stable(o6_o) && $stable(o5_o))));

    // R10
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (o6_o == '0 && o5_o == '0));

    logic unused_in;
    assign unused_in = ^{lut_byp_i};

endmodule

bind dram_slice dram_slice_chk #(.NUM_LUT(NUM_LUT), .ADDR_W(ADDR_W)) i_slice_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .lut_mode_i (lut_mode_i),
    .lut_addr_i (lut_addr_i),
    .lut_byp_i  (lut_byp_i),
    .lut_din_i  (lut_din_i),
    .o6_o       (o6_o),
    .o5_o       (o5_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/test_dram_slice.sv
module test_dram_slice;

    localparam int NL = 4;
    localparam int AW = 6;
    localparam int NV = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [NL-1:0][2:0] mode = '0;
    logic [NL-1:0][AW-1:0] addr = '0;
    logic [NL-1:0]     byp = '0;
    logic [NL-1:0]     din = '0;
    logic [NL-1:0]     o6, o5;
    logic              err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [63:0] ref_mem [NL];

    always #5 clk = ~clk;

    dram_slice i_dram_slice (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we),
        .lut_mode_i(mode), .lut_addr_i(addr), .lut_byp_i(byp), .lut_din_i(din),
        .o6_o(o6), .o5_o(o5), .cfg_err_o(err)
    );

    // {modes D C B A (3b each), addrs D C B A (6b each), byp, din, we}
    localparam logic [44:0] VEC [NV] = '{
        {12'o3333, 24'o01020304, 4'h0, 4'hF, 1'b1},
        {12'o3333, 24'o77776655, 4'h0, 4'h5, 1'b1},
        {12'o3333, 24'o01020304, 4'h0, 4'h0, 1'b0},
        {12'o1111, 24'o41424344, 4'hA, 4'h6, 1'b1},
        {12'o1111, 24'o01020304, 4'h0, 4'h0, 1'b0},
        {12'o3444, 24'o20101112, 4'h0, 4'h8, 1'b1},
        {12'o3444, 24'o20202020, 4'h0, 4'h0, 1'b0},
        {12'o3434, 24'o30313233, 4'h0, 4'h2, 1'b1},
        {12'o3434, 24'o30303230, 4'h0, 4'h0, 1'b0},
        {12'o1222, 24'o05454545, 4'hF, 4'h8, 1'b1},
        {12'o0333, 24'o00000000, 4'h0, 4'hF, 1'b1},
        {12'o3337, 24'o00000000, 4'h0, 4'hF, 1'b1},
        {12'o4333, 24'o00000000, 4'h0, 4'hF, 1'b1},
        {12'o3330, 24'o50505050, 4'h0, 4'hF, 1'b1},
        {12'o3333, 24'o50505050, 4'h0, 4'h0, 1'b0},
        {12'o3333, 24'o60606060, 4'h0, 4'hF, 1'b0}
    };
    localparam string TAG [NV] = '{
        "R2", "R2", "R2", "R3", "R3", "R4", "R5", "R5",
        "R5", "R6", "R7", "R7", "R8", "R9", "R9", "R11"
    };

    function automatic logic is_dual(input logic [2:0] m);
        return m == 3'd2 || m == 3'd4;
    endfunction

    function automatic logic model_err(input logic [NL-1:0][2:0] m);
        logic any = 1'b0, bad = 1'b0;
        for (int k = 0; k < NL; k++) begin
            if (m[k] > 3'd4) bad = 1'b1;
            if (m[k] != 3'd0) any = 1'b1;
        end
        return bad || (any && !(m[NL-1] == 3'd1 || m[NL-1] == 3'd3));
    endfunction

    function automatic logic [8:0] model_out(input logic [NL-1:0][2:0] m,
                                             input logic [NL-1:0][AW-1:0] a);
        logic [3:0] r6 = '0, r5 = '0;
        for (int k = 0; k < NL; k++) begin
            if (m[k] == 3'd1 || m[k] == 3'd2) begin
                r6[k] = ref_mem[k][{1'b1, a[k][4:0]}];
                r5[k] = ref_mem[k][{1'b0, a[k][4:0]}];
            end else if (m[k] == 3'd3 || m[k] == 3'd4) begin
                r6[k] = ref_mem[k][a[k]];
            end
        end
        return {model_err(m), r6, r5};
    endfunction

    task automatic model_write(input logic [NL-1:0][2:0] m, input logic [NL-1:0][AW-1:0] a,
                               input logic [NL-1:0] bx, input logic [NL-1:0] di, input logic w);
        logic [AW-1:0] wa;
        logic lo;
        if (!w || model_err(m)) return;
        for (int k = 0; k < NL; k++) begin
            wa = is_dual(m[k]) ? a[NL-1] : a[k];
            if (!is_dual(m[k])) lo = di[k];
            else if (k == 0)    lo = is_dual(m[1]) ? di[NL-1] : di[1];
            else                lo = di[NL-1];
            if (m[k] == 3'd1 || m[k] == 3'd2) begin
                ref_mem[k][{1'b1, wa[4:0]}] = bx[k];
                ref_mem[k][{1'b0, wa[4:0]}] = lo;
            end else if (m[k] == 3'd3 || m[k] == 3'd4) begin
                ref_mem[k][wa] = lo;
            end
        end
    endtask

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [44:0] v, input string tag);
        @(negedge clk);
        mode = v[44:33]; addr = v[32:9]; byp = v[8:5]; din = v[4:1]; we = v[0];
        #1;
        // R1: old data before the edge
        check({tag, "/R1 pre-edge"}, {err, o6, o5}, model_out(mode, addr));
        @(posedge clk);
        model_write(mode, addr, byp, din, we);
        #2;
        check({tag, " post-edge"}, {err, o6, o5}, model_out(mode, addr));
        we = 1'b0;
    endtask

    task automatic clear_model();
        for (int k = 0; k < NL; k++) ref_mem[k] = '0;
    endtask

    initial begin
        clear_model();
        mode = {3'd3, 3'd3, 3'd3, 3'd3};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state at several addresses
        for (int i = 0; i < 4; i++) begin
            addr = {4{6'(i * 17)}};
            #1;
            check("R10 reset state", {err, o6, o5}, 9'h000);
        end

        for (int i = 0; i < NV; i++) run_vec(VEC[i], TAG[i]);

        // R7: all tables off is legal
        @(negedge clk);
        mode = '0; #1;
        check("R7 all off legal", {err, o6, o5}, 9'h000);

        // R10: reset in the middle of operation clears stored data
        run_vec({12'o3333, 24'o12121212, 4'h0, 4'hF, 1'b1}, "R10 setup");
        @(negedge clk);
        rst_n = 1'b0;
        clear_model();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 mid-run reset", {err, o6, o5}, 9'h000);

        // R3: address bit 5 ignored in paired mode
        run_vec({12'o1111, 24'o07070707, 4'h5, 4'hA, 1'b1}, "R3 write");
        @(negedge clk);
        addr = {4{6'o47}}; #1;
        check("R3 bit5 ignored", {err, o6, o5}, model_out(mode, addr));
        check("R3 literal", {err, o6, o5}, {1'b0, 4'h5, 4'hA});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule